// File: doc/BRIEF.md
# Banked Interrupt Mask Controller

This block collects level-sensitive interrupt lines into three banks: two wide peripheral banks (sources 0–31 and 32–63) and one narrow basic bank of eight sources (64–71). Each bank keeps an enable mask. Software sets mask bits through one write-one register per bank and clears them through a second write-one register per bank. A bit written as zero never changes the mask, so different drivers can own different sources without a read-modify-write.

Software reads a masked view of each bank. It also reads a summary word that holds the eight masked basic sources and two flags, one for each peripheral bank that has an enabled source active. A single IRQ line to the processor is high while any enabled source in any bank is active. Pending bits are not latched. They follow the source level, so the source itself must be cleared to end a request. To initialise the block, software writes all ones to every clear register.

Register map (byte addresses, 32-bit words):
- 0x00: summary
- 0x04: masked peripheral bank 0
- 0x08: masked peripheral bank 1
- 0x10, 0x14, 0x18: enable-set registers for peripheral bank 0, peripheral bank 1 and the basic bank
- 0x1C, 0x20, 0x24: the matching enable-clear registers

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every enable mask is zero and irq_o is low, whatever the source levels.
- R2: A write to a bank's enable-set register (0x10 peripheral bank 0, 0x14 peripheral bank 1, 0x18 basic) sets every mask bit written as one and leaves every bit written as zero unchanged; the new mask is visible from the next clock edge.
- R3: A write to a bank's enable-clear register, placed 0x0C above its enable-set register (0x1C, 0x20, 0x24), clears every mask bit written as one and leaves the others unchanged.
- R4: Reading 0x04 or 0x08 returns that peripheral bank's source levels ANDed with its mask in the same cycle. A bit drops as soon as its source drops, with no latching.
- R5: The summary word at 0x00 holds the masked basic sources in bits 7:0. Bit 8 is set when any enabled source of peripheral bank 0 is active, and bit 9 is set when any enabled source of peripheral bank 1 is active. Bits 31:10 read as zero.
- R6: irq_o is high exactly when at least one enabled source in any bank is active.
- R7: Writing all ones to all three enable-clear registers masks every source: irq_o goes low and every pending view reads zero even with all sources held high.
- R8: Reading an enable-set or enable-clear register returns that bank's current mask. Unmapped addresses read zero. Writes to the summary, pending or unmapped addresses change no mask.
- R9: The basic bank uses only bits 7:0 of a written word. Its mask reads back with bits 31:8 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_periph_i | input | 64 | Peripheral source levels, bits 31:0 for bank 0 and 63:32 for bank 1 |
| src_basic_i | input | 8 | Basic bank source levels |
| bus_addr_i | input | 8 | Register byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Masked interrupt request to the processor |

## Verification
The checker tests these rules on every cycle:
- irq_o is low after reset.
- A masked view is never set where its source is low.
- The unused top bits of the summary stay zero.
- While irq_o is low, every pending view reads zero.
- After a set or clear write, reading the same register shows those bits set or cleared.

Other behaviour only the bench scenarios can show:
- Bits written as zero leave the mask unchanged.
- The two summary flags are not swapped.
- Writes to read-only or unmapped addresses change nothing.
- The mask-all initialisation holds with every source asserted.

These are judged against a bench model driven by directed cases and seeded random traffic.

// File: rtl/irqc_pkg.sv
// Package: shared sizes and register offsets of the banked interrupt controller.
// Assumes byte addresses on a 32-bit word bus; clear registers sit a fixed
// distance above their set registers.
package irqc_pkg;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int N_PERIPH    = 2;
    localparam int N_BANKS     = N_PERIPH + 1;     // peripheral banks, then basic
    localparam int BASIC_IDX   = N_PERIPH;
    localparam logic [ADDR_W-1:0] OFS_SUMMARY  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND0    = 8'h04;  // + 4*bank
    localparam logic [ADDR_W-1:0] OFS_EN_SET0  = 8'h10;  // + 4*bank
    localparam logic [ADDR_W-1:0] CLR_DELTA    = 8'h0C;

    function automatic logic [ADDR_W-1:0] pend_addr(input int bank);
        return OFS_PEND0 + ADDR_W'(4 * bank);
    endfunction

    function automatic logic [ADDR_W-1:0] set_addr(input int bank);
        return OFS_EN_SET0 + ADDR_W'(4 * bank);
    endfunction

    function automatic logic [ADDR_W-1:0] clr_addr(input int bank);
        return OFS_EN_SET0 + ADDR_W'(4 * bank) + CLR_DELTA;
    endfunction
endpackage

// File: rtl/irqc_decode.sv
// Module: irqc_decode
// Turns a bus address and write strobe into per-bank set/clear write strobes
// and per-bank hit flags for reading the mask back.
// Assumes one access per cycle, so at most one strobe is active at a time.
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    output logic [N_BANKS-1:0] set_stb_o,
    output logic [N_BANKS-1:0] clr_stb_o,
    output logic [N_BANKS-1:0] mask_hit_o
);
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic set_hit, clr_hit;
        // Match this bank's set and clear addresses.
        always_comb begin
            set_hit = (addr_i == set_addr(b));
            clr_hit = (addr_i == clr_addr(b));
        end
        assign set_stb_o[b]  = wr_i & set_hit;
        assign clr_stb_o[b]  = wr_i & clr_hit;
        assign mask_hit_o[b] = set_hit | clr_hit;
    end
endmodule

// File: rtl/irqc_bank.sv
// Module: irqc_bank
// One bank: holds the enable mask, updates it from write-one set/clear
// strobes, and produces the level-following masked view and an "any" flag.
// Assumes set and clear strobes never fire in the same cycle.
module irqc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb_i,
    input  logic         clr_stb_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] pend_o,
    output logic         any_o
);
    logic [W-1:0] mask_q;

    // Mask register: reset to all-disabled, OR in set bits, AND out clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (set_stb_i) mask_q <= mask_q | wdata_i;
        else if (clr_stb_i) mask_q <= mask_q & ~wdata_i;
    end

    // Masked view follows the source level with no latching.
    always_comb begin
        pend_o = src_i & mask_q;
        any_o  = |pend_o;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irqc_top.sv
// Module: irqc_top
// Banked interrupt mask controller: two wide peripheral banks plus a narrow
// basic bank, write-one set/clear enables, a summary word with per-bank
// flags, and a single masked IRQ. Reads are combinational from the address.
// Assumes level-sensitive sources already synchronised to clk.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int PERIPH_W = 32,
    parameter int BASIC_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_PERIPH*PERIPH_W-1:0] src_periph_i,
    input  logic [BASIC_W-1:0]           src_basic_i,
    input  logic [ADDR_W-1:0]            bus_addr_i,
    input  logic                         bus_wr_i,
    input  logic [DATA_W-1:0]            bus_wdata_i,
    output logic [DATA_W-1:0]            bus_rdata_o,
    output logic                         irq_o
);
    localparam int FLAG_LSB = BASIC_W;   // first peripheral flag in summary

    logic [N_BANKS-1:0] set_stb, clr_stb, mask_hit;
    logic [N_PERIPH-1:0][PERIPH_W-1:0] mask_p, pend_p;
    logic [N_PERIPH-1:0] any_p;
    logic [BASIC_W-1:0]  mask_b, pend_b;
    logic                any_b;

    irqc_decode u_decode (
        .addr_i    (bus_addr_i),
        .wr_i      (bus_wr_i),
        .set_stb_o (set_stb),
        .clr_stb_o (clr_stb),
        .mask_hit_o(mask_hit)
    );

    for (genvar p = 0; p < N_PERIPH; p++) begin : g_periph
        irqc_bank #(.W(PERIPH_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_stb_i(set_stb[p]),
            .clr_stb_i(clr_stb[p]),
            .wdata_i  (bus_wdata_i[PERIPH_W-1:0]),
            .src_i    (src_periph_i[p*PERIPH_W +: PERIPH_W]),
            .mask_o   (mask_p[p]),
            .pend_o   (pend_p[p]),
            .any_o    (any_p[p])
        );
    end

    irqc_bank #(.W(BASIC_W)) u_basic (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb_i(set_stb[BASIC_IDX]),
        .clr_stb_i(clr_stb[BASIC_IDX]),
        .wdata_i  (bus_wdata_i[BASIC_W-1:0]),
        .src_i    (src_basic_i),
        .mask_o   (mask_b),
        .pend_o   (pend_b),
        .any_o    (any_b)
    );

    // Read mux: summary, per-bank masked views, or a bank's mask.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == OFS_SUMMARY) begin
            bus_rdata_o[BASIC_W-1:0] = pend_b;
            for (int p = 0; p < N_PERIPH; p++) bus_rdata_o[FLAG_LSB + p] = any_p[p];
        end
        for (int p = 0; p < N_PERIPH; p++) begin
            if (bus_addr_i == pend_addr(p)) bus_rdata_o[PERIPH_W-1:0] = pend_p[p];
            if (mask_hit[p])                bus_rdata_o[PERIPH_W-1:0] = mask_p[p];
        end
        if (mask_hit[BASIC_IDX]) bus_rdata_o[BASIC_W-1:0] = mask_b;
    end

    // Single request line: any enabled active source in any bank.
    always_comb irq_o = any_b | (|any_p);
endmodule

// File: rtl/irqc_top_chk.sv
// Module: irqc_top_chk
// Cycle-by-cycle checks of the controller, seen only through its ports.
// Assumes the default 32-bit peripheral / 8-bit basic configuration.
module irqc_top_chk
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [63:0]       src_periph_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_wr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              irq_o
);
    // R1: one cycle after reset is sampled low the request is low.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !irq_o);

    // R2: bits written to bank 0 set register read back as set.
    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == set_addr(0)) |=>
        (bus_addr_i != set_addr(0) || (bus_rdata_o & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    // R3: bits written to bank 0 clear register read back as clear.
    assert_clr_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == clr_addr(0)) |=>
        (bus_addr_i != clr_addr(0) || (bus_rdata_o & $past(bus_wdata_i)) == '0));

    // R4: masked view of bank 0 is never set where its source is low.
    assert_view_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == pend_addr(0)) |-> ((bus_rdata_o & ~src_periph_i[31:0]) == '0));

    // R5: upper summary bits are always zero.
    assert_summary_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == OFS_SUMMARY) |-> (bus_rdata_o[31:10] == '0));

    // R6: with no request, every pending view reads zero.
    assert_quiet_views_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && (bus_addr_i == OFS_SUMMARY || bus_addr_i == pend_addr(0) ||
                    bus_addr_i == pend_addr(1))) |-> (bus_rdata_o == '0));
endmodule

bind irqc_top irqc_top_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_periph_i(src_periph_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_periph = '0;
    logic [7:0]  src_basic = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] m0, m1;
    logic [7:0]  mb;

    always #2.5 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_periph_i(src_periph), .src_basic_i(src_basic),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] p0, p1;
        logic [7:0]  pb;
        p0 = src_periph[31:0] & m0;
        p1 = src_periph[63:32] & m1;
        pb = src_basic & mb;
        case (a)
            8'h00:        return {22'b0, |p1, |p0, pb};
            8'h04:        return p0;
            8'h08:        return p1;
            8'h10, 8'h1C: return m0;
            8'h14, 8'h20: return m1;
            8'h18, 8'h24: return {24'b0, mb};
            default:      return '0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(src_periph[31:0] & m0) | |(src_periph[63:32] & m1) | |(src_basic & mb);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        case (a)
            8'h10: m0 = m0 | d;
            8'h14: m1 = m1 | d;
            8'h18: mb = mb | d[7:0];
            8'h1C: m0 = m0 & ~d;
            8'h20: m1 = m1 & ~d;
            8'h24: mb = mb & ~d[7:0];
            default: ;
        endcase
    endtask

    task automatic read_check(input string req, input logic [7:0] a);
        addr = a;
        #0.5;
        check(req, rdata, exp_rd(a));
    endtask

    task automatic check_all(input string req);
        read_check(req, 8'h00);
        read_check(req, 8'h04);
        read_check(req, 8'h08);
        read_check(req, 8'h10);
        read_check(req, 8'h14);
        read_check(req, 8'h18);
        check({req, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs[6];
        void'($urandom(32'h5EED_1234));
        addrs = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};
        m0 = '0; m1 = '0; mb = '0;
        src_periph = '1; src_basic = '1;
        repeat (3) @(negedge clk);
        // R1: reset state with every source asserted
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R2: set bits accumulate, zero bits leave others alone
        bus_write(8'h10, 32'h0000_00F0);
        bus_write(8'h10, 32'h0000_0001);
        read_check("R2 set accumulate", 8'h10);
        check("R2 mask value", rdata, 32'h0000_00F1);

        // R3: clear at +0x0C removes only ones
        bus_write(8'h1C, 32'h0000_0030);
        read_check("R3 clear partial", 8'h1C);
        check("R3 mask value", rdata, 32'h0000_00C1);

        // R9: basic bank keeps only low 8 bits
        bus_write(8'h18, 32'hFFFF_FF0F);
        read_check("R9 basic width", 8'h18);
        check("R9 basic value", rdata, 32'h0000_000F);

        // R8: writes to read-only/unmapped addresses change nothing
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h3C, 32'hFFFF_FFFF);
        check_all("R8 ignored writes");
        read_check("R8 unmapped", 8'h3C);
        read_check("R8 clr reads mask", 8'h24);

        // R5: flags not swapped; only bank 1 active
        bus_write(8'h14, 32'h8000_0000);
        @(negedge clk);
        src_periph = 64'h8000_0000_0000_0000; src_basic = '0;
        read_check("R5 bank1 flag", 8'h00);
        check("R5 flag bits", rdata, 32'h0000_0200);
        src_periph = 64'h0000_0000_0000_0040; src_basic = 8'h05;
        read_check("R5 bank0 flag", 8'h00);
        check("R5 flag bits b0", rdata, 32'h0000_0105);

        // R4: view follows level, no latching
        src_periph = 64'h0000_0000_0000_0080;
        read_check("R4 level high", 8'h04);
        src_periph = '0; src_basic = '0;
        @(negedge clk);
        read_check("R4 level dropped", 8'h04);
        check("R6 idle irq", {31'b0, irq}, 32'h0);

        // Random traffic: R2 R3 R4 R5 R6
        for (int i = 0; i < 300; i++) begin
            src_periph = {$urandom, $urandom};
            src_basic = 8'($urandom);
            if ($urandom_range(0, 3) == 0) src_periph = '0;
            bus_write(addrs[$urandom_range(0, 5)], $urandom & $urandom);
            check_all("R6 random");
        end

        // R7: mask-all initialisation with all sources high
        src_periph = '1; src_basic = '1;
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h18, 32'hFFFF_FFFF);
        check("R6 all enabled", {31'b0, irq}, 32'h1);
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'h24, 32'hFFFF_FFFF);
        check_all("R7 mask all");
        check("R7 irq low", {31'b0, irq}, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule